// File: doc/BRIEF.md
# Streaming 3x3 Convolver

This block filters a raster-scan stream of 8-bit pixels with a 3x3 kernel and delivers one 20-bit weighted sum per clock. Two on-block row delay lines of programmable length hold the two previous image rows. Together with the current row they form a 3x3 window. Nine 8-bit coefficients are supplied on a flat input bus, and a nine-bit configuration word sets the data formats, the input alignment delay, the rounding, and how the cascade port is used.

The 16-bit cascade input has two uses. It can carry a partial sum from another convolver, which is shifted and added to the local result, so that several blocks can build a larger kernel. It can instead carry two external rows that replace the internal delay lines, for images wider than the lines hold. The 8-bit cascade output gives the aligned pixel stream delayed by two row lengths, to feed a downstream block. A frame input clears the data path. A hold input freezes the block one clock after it is sampled.

Top module: `conv3x3_stream`

## Requirements
- R1: After the frame clear, number the active clock edges 1, 2, ... and let a(j) be the aligned pixel value after edge j. With no rounding, no cascade term and no saturation, `dout` after edge j equals the sum of the nine products coef[k]·P[k+1], k = 0..8, where coef[k] is `coef_in[8k+7:8k]`. For each row, the three taps are that row's values after edges j-4, j-5 and j-6. P1..P3 take the row two back, P4..P6 the row one back, and P7..P9 the current row. Within each group the oldest value comes first.
- R2: `cfg[3]` = 1 treats pixels as two's complement and 0 as unsigned. `cfg[4]` does the same for coefficients.
- R3: Each internal row delay line delays by L edges. L is `row_len`, and a `row_len` of 0 means L = 1024. The row one back is a(j-L) and the row two back is a(j-2L). Values from before the frame clear read as 0.
- R4: `cfg[2:1]` = d sets the alignment delay, so that a(j) equals the `pix_in` value sampled at edge j-d (d = 0..3).
- R5: With `cfg[0]` = 0, the value of `cas_in` sampled at edge j-1 is shifted left by 0, 2, 4 or 8 places for `cfg[8:7]` = 00, 01, 10, 11. The result is added to the sum that appears after edge j. That value is treated as two's complement when `cfg[3]` or `cfg[4]` is 1, and as unsigned otherwise.
- R6: With `cfg[0]` = 1, the internal lines are bypassed. For the row one back, `cas_in[7:0]` sampled at the same edge is used in place of a(j-L). For the row two back, `cas_in[15:8]` is used in place of a(j-2L).
- R7: `cas_out` between edges j and j+1 equals a(j-2L), and 0 while that index falls before the frame clear.
- R8: `cfg[6:5]` = 01 adds 8 and then zeroes `dout[3:0]`. The code 10 adds 2048 and then zeroes `dout[11:0]`. The codes 00 and 11 apply no rounding.
- R9: The rounded value saturates instead of wrapping. In the signed case (either format bit set) the limits are -524288 and 524287. In the unsigned case they are 0 and 1048575.
- R10: An edge with `frame_n` low clears every data-path register and both delay lines, so `dout` and `cas_out` read 0 after that edge.
- R11: `hold` is registered. When it is sampled high at edge e, edges e+1 onward change no state, and `pix_in` and `cas_in` are ignored until the edge after the one at which `hold` is sampled low.
- R12: An edge with `rst_n` low clears all state, including the registered hold, so `dout` and `cas_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Synchronous data-path clear at frame start, active low |
| hold | input | 1 | Freeze request, takes effect one edge after it is sampled |
| pix_in | input | 8 | Raster-scan pixel |
| cas_in | input | 16 | Cascade partial sum, or two external rows |
| coef_in | input | 72 | Nine coefficients, tap 1 in bits 7:0 |
| row_len | input | 10 | Row delay length, 0 means 1024 |
| cfg | input | 9 | Mode, delay, format, rounding and shift selects |
| dout | output | 20 | Filtered result |
| cas_out | output | 8 | Aligned pixel delayed by two rows |

## Verification
The main path is tried with a ramp-like kernel and unsigned data, which exposes tap order and the row mapping. It is then tried with mixed-sign kernels under each format pairing, which separates sign extension of the pixel from that of the coefficient. Large kernels with a wide shifted cascade term push the sum past both saturation limits in the signed and unsigned cases, and with both rounding widths. Row lengths of 1, 3 to 7 and 1024, together with alignment delays of 0, 1 and 3, separate errors in line length from errors in input alignment. A bypass run with independent cascade bytes shows whether the external rows land on the right taps. A run with a hold window in mid-stream, driving junk on the inputs during the hold, shows whether any state leaks through.

// File: rtl/conv_pkg.sv
// Shared constants and types for the 3x3 streaming convolver.
// Assumes a nine-bit configuration word with the field positions below.
package conv_pkg;
    localparam int CFG_W       = 9;
    localparam int CFG_CASMODE = 0;
    localparam int CFG_DLY_LO  = 1;
    localparam int CFG_PIXFMT  = 3;
    localparam int CFG_COEFFMT = 4;
    localparam int CFG_RND_LO  = 5;
    localparam int CFG_SHF_LO  = 7;

    // Low bits discarded by the two rounding widths
    localparam int RND_KEEP16_LO = 4;
    localparam int RND_KEEP8_LO  = 12;

    typedef enum logic [1:0] {
        RND_OFF = 2'b00,
        RND_16  = 2'b01,
        RND_8   = 2'b10,
        RND_BAD = 2'b11
    } rnd_mode_t;

    // Cascade shift distance for each select code
    function automatic logic [3:0] cas_shift_amt(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd0;
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/conv_line_delay.sv
// Programmable row delay line: dout is din delayed by len_i enabled edges
// (len_i == 0 selects MAX_LEN). A circular buffer with a fill counter stands
// in for a shift register, and reads as zero until a full row has been written.
// Assumes len_i is changed only together with a clear.
module conv_line_delay #(
    parameter int W       = 8,
    parameter int MAX_LEN = 1024,
    localparam int LEN_W  = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             en,
    input  logic [LEN_W-1:0] len_i,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    logic [W-1:0]     mem [MAX_LEN];
    logic [LEN_W-1:0] ptr;
    logic [LEN_W:0]   fill;
    logic [LEN_W:0]   eff_len;

    // Effective length, with zero meaning the full depth
    assign eff_len = (len_i == '0) ? (LEN_W+1)'(MAX_LEN) : {1'b0, len_i};

    // Pointer and fill counter advance on each enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            ptr  <= '0;
            fill <= '0;
        end else if (en) begin
            ptr <= ({1'b0, ptr} == eff_len - 1'b1) ? '0 : ptr + 1'b1;
            if (fill != eff_len) fill <= fill + 1'b1;
        end
    end

    // Storage write; contents before the fill completes are masked
    always_ff @(posedge clk) begin
        if (rst_n && clr_n && en) mem[ptr] <= din;
    end

    // Oldest entry once the line is full
    assign dout = (fill == eff_len) ? mem[ptr] : '0;

    a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        ({1'b0, ptr} < eff_len));
    a_r10_line_empty_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (dout == '0));
endmodule

// File: rtl/conv_window_mac.sv
// 3x3 window and multiply-accumulate. Three taps are kept per row; tap k+1
// (oldest first) of row2, row1, row0 pairs with coefficients 0..8 in turn.
// Products are registered, then summed into a registered result (2 stages
// after the taps). Operands extend to one extra bit following the format flags.
module conv_window_mac #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    parameter int NTAP   = 9,
    localparam int PROD_W = PIX_W + COEF_W + 2,
    localparam int SUM_W  = PROD_W + $clog2(NTAP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_n,
    input  logic                     en,
    input  logic                     pix_signed,
    input  logic                     coef_signed,
    input  logic [PIX_W-1:0]         row0,
    input  logic [PIX_W-1:0]         row1,
    input  logic [PIX_W-1:0]         row2,
    input  logic [NTAP*COEF_W-1:0]   coef_i,
    output logic signed [SUM_W-1:0]  sum_o
);
    logic [PIX_W-1:0]         rin  [3];
    logic [PIX_W-1:0]         tap  [3][3];
    logic signed [PROD_W-1:0] prod [NTAP];
    logic signed [SUM_W-1:0]  acc;

    assign rin[0] = row0;
    assign rin[1] = row1;
    assign rin[2] = row2;

    // Per-row tap shift registers, newest in tap[r][0]
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            for (int r = 0; r < 3; r++)
                for (int k = 0; k < 3; k++) tap[r][k] <= '0;
        end else if (en) begin
            for (int r = 0; r < 3; r++) begin
                tap[r][0] <= rin[r];
                tap[r][1] <= tap[r][0];
                tap[r][2] <= tap[r][1];
            end
        end
    end

    for (genvar i = 0; i < NTAP; i++) begin : g_mul
        localparam int ROW = 2 - (i / 3);
        localparam int AGE = 2 - (i % 3);
        logic signed [PIX_W:0]  pe;
        logic signed [COEF_W:0] ce;
        assign pe = {pix_signed  & tap[ROW][AGE][PIX_W-1], tap[ROW][AGE]};
        assign ce = {coef_signed & coef_i[i*COEF_W+COEF_W-1], coef_i[i*COEF_W +: COEF_W]};
        // Product register for one tap
        always_ff @(posedge clk) begin
            if (!rst_n || !clr_n) prod[i] <= '0;
            else if (en)          prod[i] <= pe * ce;
        end
    end

    // Adder tree over the registered products
    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++)
            acc = acc + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
    end

    // Sum register
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) sum_o <= '0;
        else if (en)          sum_o <= acc;
    end

    a_r10_sum_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (sum_o == '0));
endmodule

// File: rtl/conv_round_sat.sv
// Final stage: adds the shifted cascade value, rounds to the chosen width,
// saturates to the output range and registers the result. The signed limits
// apply when is_signed is set; the cascade value is sign-extended only then.
module conv_round_sat
    import conv_pkg::*;
#(
    parameter int IN_W  = 22,
    parameter int CAS_W = 16,
    parameter int OUT_W = 20,
    localparam int WIDE_W = IN_W + CAS_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_n,
    input  logic                    en,
    input  logic                    is_signed,
    input  logic                    cas_add_en,
    input  logic [1:0]              cas_shift,
    input  rnd_mode_t               rnd_mode,
    input  logic signed [IN_W-1:0]  sum_i,
    input  logic [CAS_W-1:0]        cas_i,
    output logic [OUT_W-1:0]        dout_o
);
    localparam logic signed [WIDE_W-1:0] S_MAX = {{(WIDE_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] S_MIN = {{(WIDE_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [WIDE_W-1:0] U_MAX = {{(WIDE_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};
    localparam logic signed [WIDE_W-1:0] ONE_W = {{(WIDE_W-1){1'b0}}, 1'b1};
    localparam logic [OUT_W-1:0]         ONE_O = {{(OUT_W-1){1'b0}}, 1'b1};

    logic signed [WIDE_W-1:0] cas_ext, total, half, maxv, minv, sat;
    logic [4:0]               lo;
    logic [OUT_W-1:0]         keep_mask;

    // Cascade extension, shift and add
    always_comb begin
        cas_ext = {{(WIDE_W-CAS_W){is_signed & cas_i[CAS_W-1]}}, cas_i};
        cas_ext = cas_ext <<< cas_shift_amt(cas_shift);
        total   = {{(WIDE_W-IN_W){sum_i[IN_W-1]}}, sum_i} + (cas_add_en ? cas_ext : '0);
    end

    // Rounding offset, limits and low-bit mask
    always_comb begin
        case (rnd_mode)
            RND_16:  lo = 5'(RND_KEEP16_LO);
            RND_8:   lo = 5'(RND_KEEP8_LO);
            default: lo = 5'd0;
        endcase
        half      = (lo == 5'd0) ? '0 : (ONE_W <<< (lo - 5'd1));
        keep_mask = ~((ONE_O << lo) - ONE_O);
        maxv      = is_signed ? S_MAX : U_MAX;
        minv      = is_signed ? S_MIN : '0;
        sat       = total + half;
        if (sat > maxv)      sat = maxv;
        else if (sat < minv) sat = minv;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) dout_o <= '0;
        else if (en)          dout_o <= sat[OUT_W-1:0] & keep_mask;
    end

    a_r8_round16_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en && rnd_mode == RND_16) |=> (dout_o[RND_KEEP16_LO-1:0] == '0));
    a_r8_round8_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en && rnd_mode == RND_8) |=> (dout_o[RND_KEEP8_LO-1:0] == '0));
endmodule

// File: rtl/conv3x3_stream.sv
// Top of the streaming 3x3 convolver. Registers the pixel with 0..3 extra
// alignment stages, feeds two chained row delay lines (or the cascade bytes
// in bypass mode) into the window MAC, then rounds and saturates.
// Assumes configuration changes are accompanied by a frame clear.
module conv3x3_stream
    import conv_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int COEF_W     = 8,
    parameter int CAS_W      = 2 * PIX_W,
    parameter int OUT_W      = 20,
    parameter int MAX_LEN    = 1024,
    parameter int IN_DLY_MAX = 4,
    localparam int NTAP  = 9,
    localparam int LEN_W = $clog2(MAX_LEN),
    localparam int SUM_W = PIX_W + COEF_W + 2 + $clog2(NTAP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic                   hold,
    input  logic [PIX_W-1:0]       pix_in,
    input  logic [CAS_W-1:0]       cas_in,
    input  logic [NTAP*COEF_W-1:0] coef_in,
    input  logic [LEN_W-1:0]       row_len,
    input  logic [CFG_W-1:0]       cfg,
    output logic [OUT_W-1:0]       dout,
    output logic [PIX_W-1:0]       cas_out
);
    logic                    hold_q, en, bypass, pix_s, coef_s;
    logic [PIX_W-1:0]        in_pipe [IN_DLY_MAX];
    logic [PIX_W-1:0]        aligned, line1, line2, row1, row2;
    logic [CAS_W-1:0]        cas_q;
    logic signed [SUM_W-1:0] mac_sum;

    assign en     = ~hold_q;
    assign bypass = cfg[CFG_CASMODE];
    assign pix_s  = cfg[CFG_PIXFMT];
    assign coef_s = cfg[CFG_COEFFMT];

    // Registered hold request, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold;
    end

    // Input register plus alignment chain, and the cascade capture register
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_n) begin
            for (int i = 0; i < IN_DLY_MAX; i++) in_pipe[i] <= '0;
            cas_q <= '0;
        end else if (en) begin
            in_pipe[0] <= pix_in;
            for (int i = 1; i < IN_DLY_MAX; i++) in_pipe[i] <= in_pipe[i-1];
            cas_q <= cas_in;
        end
    end

    assign aligned = in_pipe[cfg[CFG_DLY_LO +: 2]];

    conv_line_delay #(.W(PIX_W), .MAX_LEN(MAX_LEN)) u_line1 (
        .clk(clk), .rst_n(rst_n), .clr_n(frame_n), .en(en),
        .len_i(row_len), .din(aligned), .dout(line1)
    );
    conv_line_delay #(.W(PIX_W), .MAX_LEN(MAX_LEN)) u_line2 (
        .clk(clk), .rst_n(rst_n), .clr_n(frame_n), .en(en),
        .len_i(row_len), .din(line1), .dout(line2)
    );

    // Row source choice: internal lines or external rows on the cascade bus
    always_comb begin
        row1 = bypass ? cas_q[PIX_W-1:0]       : line1;
        row2 = bypass ? cas_q[CAS_W-1:PIX_W]   : line2;
    end

    assign cas_out = line2;

    conv_window_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .NTAP(NTAP)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr_n(frame_n), .en(en),
        .pix_signed(pix_s), .coef_signed(coef_s),
        .row0(aligned), .row1(row1), .row2(row2),
        .coef_i(coef_in), .sum_o(mac_sum)
    );

    conv_round_sat #(.IN_W(SUM_W), .CAS_W(CAS_W), .OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clr_n(frame_n), .en(en),
        .is_signed(pix_s | coef_s), .cas_add_en(~bypass),
        .cas_shift(cfg[CFG_SHF_LO +: 2]),
        .rnd_mode(rnd_mode_t'(cfg[CFG_RND_LO +: 2])),
        .sum_i(mac_sum), .cas_i(cas_q), .dout_o(dout)
    );

    a_r11_hold_freezes_dout: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && hold_q) |=> ($stable(dout) && $stable(cas_out)));
    a_r10_frame_clears_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (dout == '0 && cas_out == '0));
    a_r12_reset_releases_hold: assert property (@(posedge clk)
        !rst_n |=> !hold_q);
endmodule

// File: tb/test_conv3x3_stream.sv
// Table-driven bench: each row sets a configuration, clears the frame,
// streams generated pixels and compares dout / cas_out with a frame model.
module test_conv3x3_stream;
    logic        clk = 1'b0;
    logic        rst_n, frame_n, hold;
    logic [7:0]  pix_in;
    logic [15:0] cas_in;
    logic [71:0] coef_in;
    logic [9:0]  row_len;
    logic [8:0]  cfg;
    logic [19:0] dout;
    logic [7:0]  cas_out;

    always #2 clk = ~clk;

    conv3x3_stream i_conv3x3_stream (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .hold(hold),
        .pix_in(pix_in), .cas_in(cas_in), .coef_in(coef_in),
        .row_len(row_len), .cfg(cfg), .dout(dout), .cas_out(cas_out)
    );

    typedef struct packed {
        logic        hold;
        logic [8:0]  cfg;
        logic [9:0]  len;
        logic [71:0] coef;
        logic [11:0] npix;
    } scen_t;

    localparam int NSC = 15;
    localparam scen_t SCN [NSC] = '{
        '{1'b0, 9'h000, 10'd5, 72'h090807060504030201, 12'd60},  // R1 R3 unsigned
        '{1'b0, 9'h018, 10'd6, 72'h7F80FE02FF0381017C, 12'd60},  // R2 both signed
        '{1'b0, 9'h008, 10'd4, 72'hFF10203040506070E0, 12'd50},  // R2 pixel signed
        '{1'b0, 9'h010, 10'd5, 72'h80FF017F02FE03FD04, 12'd50},  // R2 coef signed
        '{1'b0, 9'h006, 10'd7, 72'h010203040506070809, 12'd60},  // R4 delay 3
        '{1'b0, 9'h002, 10'd3, 72'h11FF0322AA05339907, 12'd50},  // R4 delay 1
        '{1'b0, 9'h180, 10'd5, 72'hFFFFFFFFFFFFFFFFFF, 12'd50},  // R5 R9 shift 8 unsigned
        '{1'b0, 9'h098, 10'd6, 72'h05FB10F0207F80C040, 12'd50},  // R5 shift 2 signed
        '{1'b0, 9'h001, 10'd5, 72'h090807060504030201, 12'd50},  // R6 bypass
        '{1'b0, 9'h020, 10'd5, 72'hF0E1D2C3B4A5968778, 12'd50},  // R8 round 16
        '{1'b0, 9'h058, 10'd4, 72'h7F7F808081017F8081, 12'd50},  // R8 round 8 signed
        '{1'b0, 9'h198, 10'd5, 72'h7F807F807F807F807F, 12'd50},  // R9 signed saturation
        '{1'b0, 9'h002, 10'd0, 72'h010101010101010101, 12'd2200},// R3 R7 length 1024
        '{1'b0, 9'h000, 10'd1, 72'h030201FF0102030405, 12'd30},  // R3 R7 length 1
        '{1'b1, 9'h000, 10'd5, 72'h090807060504030201, 12'd60}   // R11 hold window
    };

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [7:0]  ph  [4096];
    logic [15:0] chh [4096];
    int m_L, m_dly;
    bit m_psg, m_csg, m_osg, m_casm;
    logic [1:0]  m_rnd, m_sh;
    logic [71:0] m_coef;

    task automatic check(input string what, input logic [19:0] got, input logic [19:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", what, got, exp);
        end
    endtask

    function automatic longint sx8(input logic [7:0] v, input bit s);
        if (s) return longint'($signed(v));
        return longint'(v);
    endfunction

    function automatic longint sx16(input logic [15:0] v, input bit s);
        if (s) return longint'($signed(v));
        return longint'(v);
    endfunction

    function automatic logic [7:0] pa(input int i);
        int k = i - m_dly;
        if (k < 1 || k > 4095) return 8'd0;
        return ph[k];
    endfunction

    function automatic logic [7:0] prow(input int r, input int i);
        if (i < 1) return 8'd0;
        if (r == 0) return pa(i);
        if (r == 1) return m_casm ? chh[i][7:0]  : pa(i - m_L);
        return            m_casm ? chh[i][15:8] : pa(i - 2 * m_L);
    endfunction

    function automatic logic [19:0] model(input int j);
        longint acc = 0, lo = 0, mx, mn;
        int t = j - 3;
        for (int idx = 0; idx < 9; idx++) begin
            int r = 2 - idx / 3;
            int k = 2 - idx % 3;
            acc += sx8(prow(r, t - 1 - k), m_psg) * sx8(m_coef[idx*8 +: 8], m_csg);
        end
        if (!m_casm && j - 1 >= 1) begin
            int sh = (m_sh == 2'd0) ? 0 : (m_sh == 2'd1) ? 2 : (m_sh == 2'd2) ? 4 : 8;
            acc += sx16(chh[j-1], m_osg) <<< sh;
        end
        if (m_rnd == 2'b01) lo = 4;
        if (m_rnd == 2'b10) lo = 12;
        if (lo != 0) acc += longint'(1) <<< (lo - 1);
        mx = m_osg ? 524287 : 1048575;
        mn = m_osg ? -524288 : 0;
        if (acc > mx) acc = mx;
        if (acc < mn) acc = mn;
        acc = acc & ~((longint'(1) <<< lo) - 1);
        return acc[19:0];
    endfunction

    task automatic run_scen(input int s);
        scen_t sc = SCN[s];
        int jj = 0, cyc = 0;
        bit prevh = 1'b0, hv;
        string tag;
        cfg = sc.cfg; row_len = sc.len; coef_in = sc.coef;
        pix_in = '0; cas_in = '0; hold = 1'b0; frame_n = 1'b0;
        for (int k = 0; k < 4096; k++) begin ph[k] = '0; chh[k] = '0; end
        m_L = (sc.len == 0) ? 1024 : int'(sc.len);
        m_dly = int'(sc.cfg[2:1]); m_casm = sc.cfg[0];
        m_psg = sc.cfg[3]; m_csg = sc.cfg[4]; m_osg = m_psg | m_csg;
        m_rnd = sc.cfg[6:5]; m_sh = sc.cfg[8:7]; m_coef = sc.coef;
        tag = sc.hold ? "R11" : "R1";
        @(negedge clk);
        frame_n = 1'b1;
        check($sformatf("R10 dout after frame s%0d", s), dout, 20'd0);
        check($sformatf("R10 cas_out after frame s%0d", s), {12'd0, cas_out}, 20'd0);
        while (jj < int'(sc.npix) + 8) begin
            hv = sc.hold && cyc >= 12 && cyc < 18;
            hold = hv;
            if (!prevh) begin
                jj++;
                if (jj <= int'(sc.npix)) begin
                    ph[jj]  = 8'(jj * 73 + s * 29 + jj * jj * 5 + (jj >> 2) * 11);
                    chh[jj] = 16'(jj * 4099 + s * 771 + jj * jj * 317);
                end
                pix_in = ph[jj]; cas_in = chh[jj];
            end else begin
                pix_in = 8'hA5 ^ 8'(cyc);
                cas_in = 16'h5A5A + 16'(cyc);
            end
            @(negedge clk);
            prevh = hv;
            cyc++;
            check($sformatf("%s dout s%0d j%0d", tag, s, jj), dout, model(jj));
            check($sformatf("R7 cas_out s%0d j%0d", s, jj), {12'd0, cas_out},
                  {12'd0, pa(jj - 2 * m_L)});
        end
        hold = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; frame_n = 1'b1; hold = 1'b1;
        pix_in = 8'hFF; cas_in = 16'hFFFF; coef_in = '1; row_len = 10'd5; cfg = 9'h000;
        repeat (3) @(negedge clk);
        check("R12 dout after reset", dout, 20'd0);
        check("R12 cas_out after reset", {12'd0, cas_out}, 20'd0);
        hold = 1'b0;
        rst_n = 1'b1;
        for (int s = 0; s < NSC; s++) run_scen(s);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule